// File: doc/BRIEF.md
# Montgomery Intra-Row Sequence Generator

This block produces the input bit positions of a turbo interleaver whose rows are each permuted by a power sequence modulo a prime. Each row keeps a current sequence value U. Each column step updates that value by one 8-bit Montgomery multiplication with a per-row constant x. A single five-stage multiplier pipeline is shared by all rows. The U values circulate through the pipeline and a feedback delay line. The x constants and row numbers circulate in a ring that advances in step with them.

Software supplies the prime, the column count, the row count (5, 10 or 20), a table of x constants and a table of permuted row numbers, then pulses start. From then on the block emits one position per cycle, covering all rows of a column before moving to the next column. It keeps running until the next start. Because the power sequence is periodic, it needs no reinitialisation between blocks that share the same parameters.

Top module: `intrarow_seq_gen`

## Requirements
- R1: After reset, and until the first start, outValid is 0 and outPos is 0.
- R2: primeP, colCount, rowCount, xTable and rowTable are sampled only on the edge where start is 1. Changing them later has no effect on the outputs until the next start.
- R3: outValid goes to 1 on the second rising edge after the start edge. It then stays 1 on every cycle until another start.
- R4: In column 0, every row uses U = 1.
- R5: In column j>0, a row's U is U(j-1)*x*256^-1 mod p. The prime p is odd, at least 7 and at most 9 bits wide. Each x is less than both p and 256, and is given as 8 bits.
- R6: Each position is T*c + U. T is the row-table entry of the row slot, taken from rowTable bits [5s+4:5s]. The slot's x is taken from xTable bits [8s+7:8s].
- R7: The row count R is 5, 10 or 20. The k-th valid output after a start (counting from 0) belongs to slot k mod R and column k div R.
- R8: Without a new start, a row's sequence repeats with period p-1. Column p-1 again uses U = 1.
- R9: A start issued while the block is running clears outValid on the next two edges. Output then resumes at column 0 with the newly sampled parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Samples the parameters and restarts the sequences |
| primeP | input | 9 | Prime modulus p (odd) |
| colCount | input | 9 | Column count c |
| rowCount | input | 5 | Row count R: 5, 10 or 20 |
| xTable | input | 160 | Per-slot Montgomery constants, 8 bits each |
| rowTable | input | 100 | Per-slot permuted row numbers, 5 bits each |
| outPos | output | 15 | Input bit position |
| outValid | output | 1 | outPos holds a position |

## Verification
The bench runs all three row counts. This matters because the feedback tap and the ring wrap point both move with R. A wrong tap shows up as rows taking U values from a neighbouring slot or from the wrong column. The primes cover both residues mod 4, which exercises both correction constants. They include 257, where U can reach 256 and the wide operand path is needed. Runs extend past p-1 columns, so a pipeline whose final reduction is missing or off by one drifts away from the wrap back to 1. Inputs are changed after start, and a restart is issued mid-stream with a different row count. Stale in-flight data, or parameters read live instead of latched, would then appear on outPos.

// File: rtl/intrarow_pkg.sv
package intrarow_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch parameters and tables, reset ring phase
    logic seedOne;  // present U=1 to the multiplier (column 0)
    logic live;     // sequence values entering post-processing are real
  } ctrlStrobes_t;
endpackage

// File: rtl/intrarow_mont_stage.sv
module intrarow_mont_stage #(
  parameter int W  = 9,
  parameter int XW = 8,
  parameter int SW = W + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  aIn,
  input  logic [XW-1:0] bIn,
  input  logic [SW-1:0] sIn,
  input  logic [W-1:0]  modP,
  input  logic [1:0]    negInv,
  output logic [W-1:0]  aOut,
  output logic [XW-1:0] bOut,
  output logic [SW-1:0] sOut
);
  logic [SW-1:0] partial;
  logic [3:0]    qProd;
  logic [SW-1:0] corrected;

  // add digit*a, then the multiple of p that clears the two low bits
  always_comb begin
    partial   = sIn + SW'(aIn) * SW'(bIn[1:0]);
    qProd     = {2'b00, partial[1:0]} * {2'b00, negInv};
    corrected = partial + SW'(modP) * SW'(qProd[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
      sOut <= '0;
    end else begin
      aOut <= aIn;
      bOut <= bIn >> 2;
      sOut <= corrected >> 2;
    end
  end
endmodule

// File: rtl/intrarow_ctrl.sv
module intrarow_ctrl
  import intrarow_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [RW-1:0] rowCount,
  output ctrlStrobes_t  strobes
);
  logic          running;
  logic [RW-1:0] seedLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      seedLeft <= '0;
    end else if (start) begin
      running  <= 1'b1;
      seedLeft <= rowCount;
    end else if (seedLeft != '0) begin
      seedLeft <= seedLeft - RW'(1);
    end
  end

  always_comb begin
    strobes.load    = start;
    strobes.seedOne = (seedLeft != '0);
    strobes.live    = running & ~start;
  end
endmodule

// File: rtl/intrarow_dp.sv
module intrarow_dp
  import intrarow_pkg::*;
#(
  parameter int ROWS_MAX = 20,
  parameter int W        = 9,
  parameter int XW       = 8,
  parameter int RW       = 5,
  parameter int CW       = 9,
  parameter int POSW     = RW + CW + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strobes,
  input  logic [W-1:0]           primeP,
  input  logic [CW-1:0]          colCount,
  input  logic [RW-1:0]          rowCount,
  input  logic [ROWS_MAX*XW-1:0] xTable,
  input  logic [ROWS_MAX*RW-1:0] rowTable,
  output logic [POSW-1:0]        outPos,
  output logic                   outValid
);
  localparam int DIGITS = XW / 2;
  localparam int STAGES = DIGITS + 1;
  localparam int DLY    = ROWS_MAX - STAGES;
  localparam int DLYIW  = (DLY > 1) ? $clog2(DLY) : 1;
  localparam int SW     = W + 3;

  typedef struct packed {
    logic [XW-1:0] x;
    logic [RW-1:0] t;
  } ringEntry_t;

  // latched parameters
  logic [W-1:0]  cfgP;
  logic [CW-1:0] cfgC;
  logic [RW-1:0] cfgRows;
  logic [1:0]    cfgNegInv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgP      <= W'(1);
      cfgC      <= '0;
      cfgRows   <= RW'(ROWS_MAX);
      cfgNegInv <= 2'd3;
    end else if (strobes.load) begin
      cfgP      <= primeP;
      cfgC      <= colCount;
      cfgRows   <= rowCount;
      cfgNegInv <= primeP[1] ? 2'd1 : 2'd3;  // -p^-1 mod 4
    end
  end

  // rotating ring of per-slot constants; wraps at slot R-1
  ringEntry_t ring [ROWS_MAX];

  for (genvar k = 0; k < ROWS_MAX; k++) begin : g_ring
    if (k == ROWS_MAX - 1) begin : g_last
      always_ff @(posedge clk) begin
        if (!rstN)             ring[k] <= '0;
        else if (strobes.load) ring[k] <= {xTable[k*XW +: XW], rowTable[k*RW +: RW]};
        else                   ring[k] <= ring[0];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (!rstN)                        ring[k] <= '0;
        else if (strobes.load)            ring[k] <= {xTable[k*XW +: XW], rowTable[k*RW +: RW]};
        else if (cfgRows == RW'(k + 1))   ring[k] <= ring[0];
        else                              ring[k] <= ring[k+1];
      end
    end
  end

  // Montgomery digit pipeline
  logic [W-1:0]  aChain [DIGITS+1];
  logic [XW-1:0] bChain [DIGITS+1];
  logic [SW-1:0] sChain [DIGITS+1];
  logic [W-1:0]  headU;
  logic [W-1:0]  fbU;
  logic [W-1:0]  redU;

  assign headU     = strobes.seedOne ? W'(1) : fbU;
  assign aChain[0] = headU;
  assign bChain[0] = ring[0].x;
  assign sChain[0] = '0;

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    intrarow_mont_stage #(.W(W), .XW(XW), .SW(SW)) u_stage (
      .clk    (clk),
      .rstN   (rstN),
      .aIn    (aChain[d]),
      .bIn    (bChain[d]),
      .sIn    (sChain[d]),
      .modP   (cfgP),
      .negInv (cfgNegInv),
      .aOut   (aChain[d+1]),
      .bOut   (bChain[d+1]),
      .sOut   (sChain[d+1])
    );
  end

  // fifth stage: one conditional subtraction
  always_ff @(posedge clk) begin
    if (!rstN)                              redU <= '0;
    else if (sChain[DIGITS] >= SW'(cfgP))   redU <= W'(sChain[DIGITS] - SW'(cfgP));
    else                                    redU <= sChain[DIGITS][W-1:0];
  end

  // feedback delay line, tapped so the loop length equals R
  logic [W-1:0]  dly [DLY];
  logic [RW-1:0] tapIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DLY; i++) dly[i] <= '0;
    end else begin
      dly[0] <= redU;
      for (int i = 1; i < DLY; i++) dly[i] <= dly[i-1];
    end
  end

  assign tapIdx = cfgRows - RW'(STAGES + 1);

  always_comb begin
    if (cfgRows == RW'(STAGES))     fbU = redU;
    else if (int'(tapIdx) < DLY)    fbU = dly[tapIdx[DLYIW-1:0]];
    else                            fbU = '0;
  end

  // post-processing: row/column, then position
  logic [RW-1:0] p1Row;
  logic [W-1:0]  p1Col;
  logic          p1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p1Row    <= '0;
      p1Col    <= '0;
      p1Valid  <= 1'b0;
      outPos   <= '0;
      outValid <= 1'b0;
    end else begin
      p1Row    <= ring[0].t;
      p1Col    <= headU;
      p1Valid  <= strobes.live;
      outPos   <= POSW'(p1Row) * POSW'(cfgC) + POSW'(p1Col);
      outValid <= p1Valid & ~strobes.load;
    end
  end
endmodule

// File: rtl/intrarow_seq_gen.sv
module intrarow_seq_gen
  import intrarow_pkg::*;
#(
  parameter int ROWS_MAX = 20,
  parameter int W        = 9,
  parameter int XW       = 8,
  parameter int RW       = 5,
  parameter int CW       = 9,
  parameter int POSW     = RW + CW + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [W-1:0]           primeP,
  input  logic [CW-1:0]          colCount,
  input  logic [RW-1:0]          rowCount,
  input  logic [ROWS_MAX*XW-1:0] xTable,
  input  logic [ROWS_MAX*RW-1:0] rowTable,
  output logic [POSW-1:0]        outPos,
  output logic                   outValid
);
  ctrlStrobes_t strobes;

  intrarow_ctrl #(.RW(RW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .rowCount (rowCount),
    .strobes  (strobes)
  );

  intrarow_dp #(
    .ROWS_MAX (ROWS_MAX), .W(W), .XW(XW), .RW(RW), .CW(CW), .POSW(POSW)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .primeP   (primeP),
    .colCount (colCount),
    .rowCount (rowCount),
    .xTable   (xTable),
    .rowTable (rowTable),
    .outPos   (outPos),
    .outValid (outValid)
  );
endmodule

// File: rtl/intrarow_seq_gen_checker.sv
module intrarow_seq_gen_checker #(
  parameter int W    = 9,
  parameter int RW   = 5,
  parameter int CW   = 9,
  parameter int POSW = RW + CW + 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [W-1:0]    primeP,
  input logic [CW-1:0]   colCount,
  input logic [RW-1:0]   rowCount,
  input logic [POSW-1:0] outPos,
  input logic            outValid
);
  logic       seenStart;
  logic [1:0] sinceStart;
  int         limRows, limC, limP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenStart  <= 1'b0;
      sinceStart <= '0;
      limRows    <= 0;
      limC       <= 0;
      limP       <= 0;
    end else if (start) begin
      seenStart  <= 1'b1;
      sinceStart <= '0;
      limRows    <= int'(rowCount);
      limC       <= int'(colCount);
      limP       <= int'(primeP);
    end else if (sinceStart != 2'd2) begin
      sinceStart <= sinceStart + 2'd1;
    end
  end

  // R1: nothing valid before the first start
  a_r1_quiet_before_start: assert property (@(posedge clk) disable iff (!rstN)
    !seenStart |-> !outValid);

  // R9: first edge after a start shows no output
  a_r9_gap_first: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !outValid);

  // R9: second edge after a start shows no output either
  a_r9_gap_second: assert property (@(posedge clk) disable iff (!rstN)
    (seenStart && sinceStart == 2'd0 && !start) |=> !outValid);

  // R3: valid from the second edge on, continuously
  a_r3_valid_held: assert property (@(posedge clk) disable iff (!rstN)
    (seenStart && sinceStart != 2'd0 && !start) |=> outValid);

  // R7: row count restricted to the three supported values
  a_r7_row_count: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (rowCount == RW'(5) || rowCount == RW'(10) || rowCount == RW'(20)));

  // R5: modulus odd and at least 7
  a_r5_odd_modulus: assert property (@(posedge clk) disable iff (!rstN)
    start |-> (primeP[0] && primeP >= W'(7)));

  // R6: position within the row-by-column space plus one residue
  a_r6_pos_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (int'(outPos) < limRows * limC + limP));
endmodule

bind intrarow_seq_gen intrarow_seq_gen_checker #(
  .W(W), .RW(RW), .CW(CW), .POSW(POSW)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .primeP   (primeP),
  .colCount (colCount),
  .rowCount (rowCount),
  .outPos   (outPos),
  .outValid (outValid)
);

// File: tb/intrarow_seq_gen_test.sv
module intrarow_seq_gen_test;
  localparam int ROWS_MAX = 20;
  localparam int W = 9, XW = 8, RW = 5, CW = 9;
  localparam int POSW = RW + CW + 1;

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   start = 1'b0;
  logic [W-1:0]           primeP = '0;
  logic [CW-1:0]          colCount = '0;
  logic [RW-1:0]          rowCount = '0;
  logic [ROWS_MAX*XW-1:0] xTable = '0;
  logic [ROWS_MAX*RW-1:0] rowTable = '0;
  logic [POSW-1:0]        outPos;
  logic                   outValid;

  always #2 clk = ~clk;

  intrarow_seq_gen uut (
    .clk(clk), .rstN(rstN), .start(start), .primeP(primeP),
    .colCount(colCount), .rowCount(rowCount), .xTable(xTable),
    .rowTable(rowTable), .outPos(outPos), .outValid(outValid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit mRun = 0;
  int mN, mK, mRows, mP, mC, mInv;
  int mX [ROWS_MAX];
  int mT [ROWS_MAX];
  int mU [ROWS_MAX];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic stepCycle(string tag);
    @(posedge clk);
    if (rstN && start) begin
      mRun = 1; mN = 0; mK = 0;
      mRows = int'(rowCount); mP = int'(primeP); mC = int'(colCount);
      for (int k = 0; k < ROWS_MAX; k++) begin
        mX[k] = int'(xTable[k*XW +: XW]);
        mT[k] = int'(rowTable[k*RW +: RW]);
        mU[k] = 1;
      end
      mInv = 0;
      for (int i = 1; i < mP; i++) if ((256 * i) % mP == 1) mInv = i;
    end else if (mRun) begin
      mN++;
    end
    @(negedge clk);
    if (mRun && mN >= 2) begin
      int r, col, expP;
      string t;
      r = mK % mRows;
      col = mK / mRows;
      expP = mT[r] * mC + mU[r];
      if (col == 0) t = "R4";
      else if (col % (mP - 1) == 0) t = "R8";
      else t = tag;
      check(outValid == 1'b1, "R3", int'(outValid), 1);
      check(int'(outPos) == expP, t, int'(outPos), expP);
      mU[r] = (mU[r] * mX[r] % mP) * mInv % mP;
      mK++;
    end else begin
      check(outValid == 1'b0, mRun ? "R9" : "R1", int'(outValid), 0);
    end
  endtask

  task automatic launch(int rows, int p, int c, int seed, string tag);
    int xm;
    xm = (p - 1 < 255) ? p - 1 : 255;
    primeP = W'(p);
    colCount = CW'(c);
    rowCount = RW'(rows);
    for (int k = 0; k < ROWS_MAX; k++) begin
      xTable[k*XW +: XW] = XW'(1 + (k * seed + 3) % xm);
      rowTable[k*RW +: RW] = RW'((k * 3 + 1) % rows);
    end
    start = 1'b1;
    stepCycle(tag);
    start = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(outPos == '0, "R1", int'(outPos), 0);
    for (int i = 0; i < 4; i++) stepCycle("R1");
    check(outPos == '0, "R1", int'(outPos), 0);

    // R5: five rows, p = 7 (p mod 4 = 3), two full periods
    launch(5, 7, 6, 2, "R5");
    for (int i = 0; i < 75; i++) stepCycle("R5");

    // R6: ten rows, p = 257 (p mod 4 = 1), wide U values
    launch(10, 257, 256, 5, "R6");
    for (int i = 0; i < 6; i++) stepCycle("R6");
    // R2: disturb every parameter input after the start edge
    primeP = W'(13);
    colCount = CW'(3);
    rowCount = RW'(5);
    xTable = {ROWS_MAX*XW{1'b1}};
    rowTable = '0;
    for (int i = 0; i < 300; i++) stepCycle("R2");

    // R7: twenty rows, p = 101
    launch(20, 101, 100, 7, "R7");
    for (int i = 0; i < 150; i++) stepCycle("R7");

    // R9: restart mid-stream with ten rows, p = 13, past one period
    launch(10, 13, 12, 3, "R9");
    for (int i = 0; i < 140; i++) stepCycle("R9");

    // R7: five rows right after ten, p = 11
    launch(5, 11, 10, 4, "R7");
    for (int i = 0; i < 60; i++) stepCycle("R7");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule